// File: doc/BRIEF.md
# Flash Command Snoop and Lane Switcher

This block sits beside the transmit shifter of a quad-capable SPI master. It watches each byte as the master transfers it. The first byte after a chip select is taken as the flash command. The block then counts the address bytes and the dummy bytes that follow that command. From this count it decides how many data lines (1, 2 or 4) the shifter drives. It also reports how many serial clocks each dummy byte lasts. The command decoder is outside the block. It returns, in the same cycle as the command byte, three results: whether the command is known, its dummy-byte count, and its lane-width code.

On the receive side the block decides whether each byte is kept or dropped. A byte is dropped when a drain request is set, while a discard counter is running, or when the receive FIFO is full. The discard counter is loaded when a chip select asserts. For a two-bus striped memory pair, the block bit-interleaves the outgoing byte pair across the two buses and undoes the interleave on the returning pair. It does this only while the data phase is active.

States, as driven on `snoop_state`:
- CHECK (0): waiting for the command.
- ADDR (1): counting address bytes.
- DUMMY (2): counting dummy bytes.
- DATA (3): data phase.
- PASS (4): pass-through for an unknown command.

Transitions:
- CHECK→PASS on an unknown command, CHECK→ADDR on a known one.
- ADDR→DUMMY, or ADDR→DATA when the dummy count is zero, on the last address byte.
- DUMMY→DATA on the last dummy byte.
- Any state→CHECK on a chip-select assertion.

Top module: `flash_cmd_snoop`

## Requirements
- R1: After reset, `snoop_state` is CHECK (0), `lane_width` is 1, and `dummy_byte`, `rx_keep` and `rx_overflow` are low.
- R2: A `cs_assert` cycle returns the state to CHECK and `lane_width` to 1 on the next cycle, and loads the discard counter from `discard_init`. A byte flagged in that same cycle is ignored: it produces no keep, overflow or dummy output and does not advance any count.
- R3: In CHECK, an accepted byte with `dec_known` low moves the state to PASS. With `dec_known` high it moves the state to ADDR.
- R4: The address phase lasts 4 bytes when `ext_addr` is high on the command byte, and 3 bytes otherwise.
- R5: After the last address byte the state becomes DUMMY when `dec_dummies` was nonzero. It becomes DATA directly when `dec_dummies` was 0. After the stored number of dummy bytes the state becomes DATA.
- R6: A byte accepted in DUMMY raises `dummy_byte`, with `dummy_clocks` equal to 8 divided by the current `lane_width`. Otherwise `dummy_clocks` is 0.
- R7: For `dec_lanes` code 1 (dual) or 2 (quad), `lane_width` becomes 2 or 4 once address-length plus dummy-count further bytes have been accepted after the command byte. Codes 0 and 3 leave `lane_width` at 1.
- R8: While the discard counter is nonzero, an accepted byte is dropped (`rx_keep` low). The counter then decreases by 8 divided by the current `lane_width`, stopping at 0.
- R9: With `rx_drain` high, an accepted byte is dropped and `rx_overflow` stays low. The discard counter is left unchanged.
- R10: With no drain and the discard counter at 0, a byte accepted while `rx_full` is high is dropped and raises `rx_overflow` for that cycle. Otherwise it is kept.
- R11: `stripe_active` is high when `stripe_en` is high in DATA. Then `tx_pair_out` carries the pair in bit order: byte 0 bits 7..0, then byte 1 bits 7..0. These bits are dealt in turn to bus 0 and bus 1, each bus filled MSB first. `rx_pair_out` applies the inverse. When `stripe_active` is low, both pairs pass through unchanged.
- R12: PASS and DATA hold until the next `cs_assert`, whatever bytes arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cs_assert | input | 1 | Chip select newly asserts this cycle |
| byte_valid | input | 1 | A byte is transferred this cycle |
| ext_addr | input | 1 | Extended (4-byte) addressing selected |
| dec_known | input | 1 | Decoder recognises the current byte as a command |
| dec_dummies | input | DUMMY_W | Decoder dummy-byte count |
| dec_lanes | input | 2 | Decoder lane code: 0 single, 1 dual, 2 quad, 3 single |
| discard_init | input | DISC_W | Receive discard count loaded on chip select |
| rx_drain | input | 1 | Drop every received byte |
| rx_full | input | 1 | Receive FIFO is full |
| stripe_en | input | 1 | Two-bus striping configured |
| tx_pair_in | input | NB*8 | Outgoing byte group, byte i at bits [8i+7:8i] |
| rx_pair_in | input | NB*8 | Returning byte group, bus j at bits [8j+7:8j] |
| snoop_state | output | 3 | Current state code |
| lane_width | output | 3 | Data lines in use: 1, 2 or 4 |
| dummy_byte | output | 1 | Current byte is a dummy byte |
| dummy_clocks | output | 4 | Serial clocks for the current dummy byte |
| rx_keep | output | 1 | Received byte goes to the FIFO |
| rx_overflow | output | 1 | Received byte lost to a full FIFO |
| stripe_active | output | 1 | Interleave applied this cycle |
| tx_pair_out | output | NB*8 | Per-bus outgoing bytes |
| rx_pair_out | output | NB*8 | Restored returning bytes |

## Verification
The byte-level results depend only on the registered state and the current inputs. These are `dummy_byte`, `dummy_clocks`, `rx_keep`, `rx_overflow` and both pair outputs, and they are due in the same cycle as the byte. The bench therefore compares them shortly after it drives the inputs, before the next rising edge. `snoop_state` and `lane_width` are registered. A byte or chip select accepted at one rising edge shows up on these two outputs in the following cycle. The behavioural model therefore updates after each rising edge, and the next comparison sees the effect one cycle later.

// File: rtl/snoop_pkg.sv
package snoop_pkg;

    typedef enum logic [2:0] {
        ST_CHECK = 3'd0,
        ST_ADDR  = 3'd1,
        ST_DUMMY = 3'd2,
        ST_DATA  = 3'd3,
        ST_PASS  = 3'd4
    } snoop_state_t;

    // lane code: width = 1 << code
    typedef enum logic [1:0] {
        LN_X1 = 2'd0,
        LN_X2 = 2'd1,
        LN_X4 = 2'd2
    } lane_t;

    function automatic lane_t lane_of_code(input logic [1:0] code);
        unique case (code)
            2'd1:    return LN_X2;
            2'd2:    return LN_X4;
            default: return LN_X1;
        endcase
    endfunction

endpackage

// File: rtl/snoop_phase_fsm.sv
module snoop_phase_fsm
    import snoop_pkg::*;
#(
    parameter int ADDR_SHORT = 3,
    parameter int ADDR_LONG  = 4,
    parameter int DUMMY_W    = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs_assert,
    input  logic               accept,
    input  logic               ext_addr,
    input  logic               dec_known,
    input  logic [DUMMY_W-1:0] dec_dummies,
    input  logic [1:0]         dec_lanes,
    output snoop_state_t       state_o,
    output lane_t              lane_o
);

    localparam int AC_W = $clog2(ADDR_LONG) + 1;
    localparam int SW_W = $clog2(ADDR_LONG + (1 << DUMMY_W)) + 1;

    snoop_state_t       state_q, state_d;
    lane_t              lane_q, lane_d;
    lane_t              next_q, next_d;
    logic [SW_W-1:0]    sw_q, sw_d;
    logic [AC_W-1:0]    al_q, al_d;
    logic [DUMMY_W-1:0] dl_q, dl_d;

    logic [AC_W-1:0]    alen;
    lane_t              cmd_lane;

    assign alen     = ext_addr ? AC_W'(ADDR_LONG) : AC_W'(ADDR_SHORT);
    assign cmd_lane = lane_of_code(dec_lanes);

    // next-state process
    always_comb begin
        state_d = state_q;
        lane_d  = lane_q;
        next_d  = next_q;
        sw_d    = sw_q;
        al_d    = al_q;
        dl_d    = dl_q;
        if (accept) begin
            if (sw_q != '0) begin
                sw_d = sw_q - 1'b1;
                if (sw_q == SW_W'(1)) begin
                    lane_d = next_q;
                end
            end
            unique case (state_q)
                ST_CHECK: begin
                    if (!dec_known) begin
                        state_d = ST_PASS;
                    end else begin
                        state_d = ST_ADDR;
                        al_d    = alen - 1'b1;
                        dl_d    = dec_dummies;
                        if (cmd_lane != LN_X1) begin
                            next_d = cmd_lane;
                            sw_d   = SW_W'(alen) + SW_W'(dec_dummies);
                        end
                    end
                end
                ST_ADDR: begin
                    if (al_q == '0) begin
                        state_d = (dl_q == '0) ? ST_DATA : ST_DUMMY;
                    end else begin
                        al_d = al_q - 1'b1;
                    end
                end
                ST_DUMMY: begin
                    dl_d = dl_q - 1'b1;
                    if (dl_q == DUMMY_W'(1)) begin
                        state_d = ST_DATA;
                    end
                end
                ST_DATA, ST_PASS: begin
                    state_d = state_q;
                end
                default: state_d = ST_CHECK;
            endcase
        end
    end

    // state register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_CHECK;
            lane_q  <= LN_X1;
            next_q  <= LN_X1;
            sw_q    <= '0;
            al_q    <= '0;
            dl_q    <= '0;
        end else if (cs_assert) begin
            state_q <= ST_CHECK;
            lane_q  <= LN_X1;
            next_q  <= LN_X1;
            sw_q    <= '0;
            al_q    <= '0;
            dl_q    <= '0;
        end else begin
            state_q <= state_d;
            lane_q  <= lane_d;
            next_q  <= next_d;
            sw_q    <= sw_d;
            al_q    <= al_d;
            dl_q    <= dl_d;
        end
    end

    assign state_o = state_q;
    assign lane_o  = lane_q;

endmodule

// File: rtl/rx_discard_ctl.sv
module rx_discard_ctl
    import snoop_pkg::*;
#(
    parameter int DISC_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_assert,
    input  logic              accept,
    input  logic [DISC_W-1:0] discard_init,
    input  logic              rx_drain,
    input  logic              rx_full,
    input  lane_t             lane,
    output logic              rx_keep,
    output logic              rx_overflow
);

    logic [DISC_W-1:0] cnt_q;
    logic [DISC_W-1:0] step;
    logic              counting;

    assign step     = DISC_W'(4'd8 >> lane);
    assign counting = (cnt_q != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cs_assert) begin
            cnt_q <= discard_init;
        end else if (accept && !rx_drain && counting) begin
            cnt_q <= (cnt_q > step) ? cnt_q - step : '0;
        end
    end

    assign rx_keep     = accept && !rx_drain && !counting && !rx_full;
    assign rx_overflow = accept && !rx_drain && !counting &&  rx_full;

endmodule

// File: rtl/lane_interleave.sv
module lane_interleave #(
    parameter int NB      = 2,
    parameter bit REVERSE = 1'b0
) (
    input  logic [NB*8-1:0] din,
    output logic [NB*8-1:0] dout
);

    localparam int NBITS = NB * 8;

    // stream bit k: source byte k/8, bit 7-k%8 -> bus k%NB, bit 7-k/NB
    for (genvar k = 0; k < NBITS; k++) begin : g_bit
        localparam int SRC = (k / 8) * 8 + (7 - (k % 8));
        localparam int DST = (k % NB) * 8 + (7 - (k / NB));
        if (REVERSE) begin : g_rev
            assign dout[SRC] = din[DST];
        end else begin : g_fwd
            assign dout[DST] = din[SRC];
        end
    end

endmodule

// File: rtl/flash_cmd_snoop.sv
module flash_cmd_snoop
    import snoop_pkg::*;
#(
    parameter int ADDR_SHORT = 3,
    parameter int ADDR_LONG  = 4,
    parameter int DUMMY_W    = 4,
    parameter int DISC_W     = 7,
    parameter int NB         = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs_assert,
    input  logic               byte_valid,
    input  logic               ext_addr,
    input  logic               dec_known,
    input  logic [DUMMY_W-1:0] dec_dummies,
    input  logic [1:0]         dec_lanes,
    input  logic [DISC_W-1:0]  discard_init,
    input  logic               rx_drain,
    input  logic               rx_full,
    input  logic               stripe_en,
    input  logic [NB*8-1:0]    tx_pair_in,
    input  logic [NB*8-1:0]    rx_pair_in,
    output logic [2:0]         snoop_state,
    output logic [2:0]         lane_width,
    output logic               dummy_byte,
    output logic [3:0]         dummy_clocks,
    output logic               rx_keep,
    output logic               rx_overflow,
    output logic               stripe_active,
    output logic [NB*8-1:0]    tx_pair_out,
    output logic [NB*8-1:0]    rx_pair_out
);

    snoop_state_t    state;
    lane_t           lane;
    logic            accept;
    logic [NB*8-1:0] tx_ilv, rx_dil;

    assign accept = byte_valid && !cs_assert;

    snoop_phase_fsm #(
        .ADDR_SHORT (ADDR_SHORT),
        .ADDR_LONG  (ADDR_LONG),
        .DUMMY_W    (DUMMY_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_assert   (cs_assert),
        .accept      (accept),
        .ext_addr    (ext_addr),
        .dec_known   (dec_known),
        .dec_dummies (dec_dummies),
        .dec_lanes   (dec_lanes),
        .state_o     (state),
        .lane_o      (lane)
    );

    rx_discard_ctl #(
        .DISC_W (DISC_W)
    ) u_disc (
        .clk          (clk),
        .rst_n        (rst_n),
        .cs_assert    (cs_assert),
        .accept       (accept),
        .discard_init (discard_init),
        .rx_drain     (rx_drain),
        .rx_full      (rx_full),
        .lane         (lane),
        .rx_keep      (rx_keep),
        .rx_overflow  (rx_overflow)
    );

    lane_interleave #(.NB(NB), .REVERSE(1'b0)) u_tx_ilv (
        .din  (tx_pair_in),
        .dout (tx_ilv)
    );

    lane_interleave #(.NB(NB), .REVERSE(1'b1)) u_rx_dil (
        .din  (rx_pair_in),
        .dout (rx_dil)
    );

    // output process
    always_comb begin
        snoop_state   = state;
        lane_width    = 3'(3'd1 << lane);
        dummy_byte    = accept && (state == ST_DUMMY);
        dummy_clocks  = dummy_byte ? 4'(4'd8 >> lane) : 4'd0;
        stripe_active = stripe_en && (state == ST_DATA);
        tx_pair_out   = stripe_active ? tx_ilv : tx_pair_in;
        rx_pair_out   = stripe_active ? rx_dil : rx_pair_in;
    end

endmodule

// File: rtl/flash_cmd_snoop_chk.sv
module flash_cmd_snoop_chk #(
    parameter int DUMMY_W = 4,
    parameter int DISC_W  = 7,
    parameter int NB      = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cs_assert,
    input logic               byte_valid,
    input logic               dec_known,
    input logic               rx_drain,
    input logic               rx_full,
    input logic [2:0]         snoop_state,
    input logic [2:0]         lane_width,
    input logic               dummy_byte,
    input logic [3:0]         dummy_clocks,
    input logic               rx_keep,
    input logic               rx_overflow
);

    a_r2_cs_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        cs_assert |=> (snoop_state == 3'd0) && (lane_width == 3'd1));

    a_r3_unknown_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (snoop_state == 3'd0 && byte_valid && !cs_assert && !dec_known)
        |=> snoop_state == 3'd4);

    a_r6_dummy_clocks: assert property (@(posedge clk) disable iff (!rst_n)
        dummy_byte |-> ((lane_width == 3'd1 && dummy_clocks == 4'd8) ||
                        (lane_width == 3'd2 && dummy_clocks == 4'd4) ||
                        (lane_width == 3'd4 && dummy_clocks == 4'd2)));

    a_r7_lane_legal: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(lane_width) == 1) && (lane_width <= 3'd4));

    a_r9_drain_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && rx_drain) |-> (!rx_keep && !rx_overflow));

    a_r10_overflow_drops: assert property (@(posedge clk) disable iff (!rst_n)
        rx_overflow |-> (!rx_keep && rx_full));

    a_r12_pass_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (snoop_state == 3'd4 && !cs_assert) |=> snoop_state == 3'd4);

    a_r12_data_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (snoop_state == 3'd3 && !cs_assert) |=> snoop_state == 3'd3);

endmodule

bind flash_cmd_snoop flash_cmd_snoop_chk #(
    .DUMMY_W (DUMMY_W),
    .DISC_W  (DISC_W),
    .NB      (NB)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cs_assert    (cs_assert),
    .byte_valid   (byte_valid),
    .dec_known    (dec_known),
    .rx_drain     (rx_drain),
    .rx_full      (rx_full),
    .snoop_state  (snoop_state),
    .lane_width   (lane_width),
    .dummy_byte   (dummy_byte),
    .dummy_clocks (dummy_clocks),
    .rx_keep      (rx_keep),
    .rx_overflow  (rx_overflow)
);

// File: tb/test_flash_cmd_snoop.sv
module test_flash_cmd_snoop;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_assert = 0, byte_valid = 0, ext_addr = 0, dec_known = 0;
    logic [3:0]  dec_dummies = 0;
    logic [1:0]  dec_lanes = 0;
    logic [6:0]  discard_init = 0;
    logic        rx_drain = 0, rx_full = 0, stripe_en = 0;
    logic [15:0] tx_pair_in = 0, rx_pair_in = 0;
    logic [2:0]  snoop_state, lane_width;
    logic        dummy_byte, rx_keep, rx_overflow, stripe_active;
    logic [3:0]  dummy_clocks;
    logic [15:0] tx_pair_out, rx_pair_out;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // behavioural reference state
    int m_st = 0, m_lane = 1, m_next = 1, m_sw = 0, m_al = 0, m_dl = 0, m_disc = 0;

    always #4 clk = ~clk;

    flash_cmd_snoop i_flash_cmd_snoop (
        .clk(clk), .rst_n(rst_n), .cs_assert(cs_assert), .byte_valid(byte_valid),
        .ext_addr(ext_addr), .dec_known(dec_known), .dec_dummies(dec_dummies),
        .dec_lanes(dec_lanes), .discard_init(discard_init), .rx_drain(rx_drain),
        .rx_full(rx_full), .stripe_en(stripe_en), .tx_pair_in(tx_pair_in),
        .rx_pair_in(rx_pair_in), .snoop_state(snoop_state), .lane_width(lane_width),
        .dummy_byte(dummy_byte), .dummy_clocks(dummy_clocks), .rx_keep(rx_keep),
        .rx_overflow(rx_overflow), .stripe_active(stripe_active),
        .tx_pair_out(tx_pair_out), .rx_pair_out(rx_pair_out)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // pair interleave per R11: stream byte0[7..0], byte1[7..0] dealt to buses MSB first
    function automatic logic [15:0] ilv(input logic [15:0] v, input bit rev);
        logic [15:0] r = '0;
        for (int k = 0; k < 16; k++) begin
            int s = (k / 8) * 8 + 7 - (k % 8);
            int d = (k % 2) * 8 + 7 - (k / 2);
            if (rev) r[s] = v[d];
            else     r[d] = v[s];
        end
        return r;
    endfunction

    task automatic compare();
        bit acc = byte_valid && !cs_assert;
        bit e_dum = acc && (m_st == 2);
        bit e_act = stripe_en && (m_st == 3);
        chk("R3 R5 R12 state", snoop_state, m_st);
        chk("R7 lane", lane_width, m_lane);
        chk("R6 dummy", {dummy_byte, dummy_clocks}, {e_dum, 4'(e_dum ? 8 / m_lane : 0)});
        chk("R8 R9 keep", rx_keep, acc && !rx_drain && m_disc == 0 && !rx_full);
        chk("R10 overflow", rx_overflow, acc && !rx_drain && m_disc == 0 && rx_full);
        chk("R11 stripe", {stripe_active, tx_pair_out, rx_pair_out},
            {e_act, e_act ? ilv(tx_pair_in, 0) : tx_pair_in,
                    e_act ? ilv(rx_pair_in, 1) : rx_pair_in});
    endtask

    task automatic model_update();
        bit acc = byte_valid && !cs_assert;
        if (cs_assert) begin
            m_st = 0; m_lane = 1; m_next = 1; m_sw = 0; m_al = 0; m_dl = 0;
            m_disc = discard_init;
        end else if (acc) begin
            int alen = ext_addr ? 4 : 3;
            if (!rx_drain && m_disc != 0) begin
                m_disc = m_disc - 8 / m_lane;
                if (m_disc < 0) m_disc = 0;
            end
            if (m_sw != 0) begin
                m_sw--;
                if (m_sw == 0) m_lane = m_next;
            end
            case (m_st)
                0: if (!dec_known) m_st = 4;
                   else begin
                       m_st = 1; m_al = alen - 1; m_dl = dec_dummies;
                       if (dec_lanes == 1 || dec_lanes == 2) begin
                           m_next = (dec_lanes == 1) ? 2 : 4;
                           m_sw = alen + dec_dummies;
                       end
                   end
                1: if (m_al == 0) m_st = (m_dl == 0) ? 3 : 2;
                   else m_al--;
                2: begin if (m_dl == 1) m_st = 3; m_dl--; end
                default: ;
            endcase
        end
    endtask

    // inputs already set at the falling edge
    task automatic tick();
        #1 compare();
        @(posedge clk);
        #1 model_update();
        @(negedge clk);
    endtask

    task automatic byte_in(input bit known, input bit ext, input int dum, input int ln);
        cs_assert = 0; byte_valid = 1; dec_known = known; ext_addr = ext;
        dec_dummies = 4'(dum); dec_lanes = 2'(ln);
        tick();
    endtask

    task automatic cs_pulse(input int disc);
        cs_assert = 1; byte_valid = 0; discard_init = 7'(disc);
        tick();
        cs_assert = 0;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset values
        chk("R1 state", snoop_state, 0);
        chk("R1 lane", lane_width, 1);
        chk("R1 outputs", {dummy_byte, rx_keep, rx_overflow}, 0);
        rst_n = 1;
        @(negedge clk);

        // quad, 3-byte address, one dummy byte
        cs_pulse(0);
        byte_in(1, 0, 1, 2);
        chk("R3 known to ADDR", snoop_state, 1);
        byte_in(0, 0, 0, 0); byte_in(0, 0, 0, 0);
        chk("R4 still addr after 2", snoop_state, 1);
        byte_in(0, 0, 0, 0);
        chk("R5 to DUMMY", snoop_state, 2);
        byte_valid = 1; #1;
        chk("R6 dummy at lane 1", dummy_clocks, 8);
        tick();
        chk("R7 quad lanes", lane_width, 4);
        chk("R5 to DATA", snoop_state, 3);
        // R11 stripe in data
        stripe_en = 1; tx_pair_in = 16'h00FF; rx_pair_in = 16'hF0F0; #1;
        chk("R11 tx interleave", tx_pair_out, 16'hF0F0);
        chk("R11 rx deinterleave", rx_pair_out, 16'h00FF);
        tick();
        stripe_en = 0;

        // dual, ext address, no dummies
        cs_pulse(0);
        byte_in(1, 1, 0, 1);
        byte_in(0, 0, 0, 0); byte_in(0, 0, 0, 0); byte_in(0, 0, 0, 0);
        chk("R4 ext address needs 4", snoop_state, 1);
        chk("R7 lane still 1", lane_width, 1);
        byte_in(0, 0, 0, 0);
        chk("R5 zero dummies to DATA", snoop_state, 3);
        chk("R7 dual lanes", lane_width, 2);
        for (int i = 0; i < 4; i++) byte_in(0, 0, 0, 0);
        chk("R12 DATA holds", snoop_state, 3);

        // unknown command
        cs_pulse(0);
        chk("R2 cs to CHECK", snoop_state, 0);
        chk("R2 cs lane 1", lane_width, 1);
        byte_in(0, 0, 3, 2);
        chk("R3 unknown to PASS", snoop_state, 4);
        for (int i = 0; i < 5; i++) byte_in(1, 0, 1, 2);
        chk("R12 PASS holds", snoop_state, 4);
        chk("R7 PASS lane 1", lane_width, 1);

        // chip select and byte in the same cycle
        cs_assert = 1; byte_valid = 1; dec_known = 1; discard_init = 0; #1;
        chk("R2 same-cycle byte no keep", rx_keep, 0);
        tick();
        chk("R2 same-cycle byte ignored", snoop_state, 0);

        // discard 40 with quad, no dummies
        cs_pulse(40);
        byte_in(1, 0, 0, 2);
        for (int i = 0; i < 3; i++) byte_in(0, 0, 0, 0);
        chk("R7 quad after addr", lane_width, 4);
        for (int i = 0; i < 3; i++) byte_in(0, 0, 0, 0);
        byte_valid = 1; #1;
        chk("R8 still discarding", rx_keep, 0);
        tick();
        #1 chk("R8 discard done", rx_keep, 1);
        tick();

        // drain and full
        cs_pulse(20);
        rx_drain = 1; rx_full = 1; byte_valid = 1; #1;
        chk("R9 drain drops", {rx_keep, rx_overflow}, 0);
        tick(); tick();
        rx_drain = 0;
        byte_in(0, 0, 0, 0); byte_in(0, 0, 0, 0); byte_in(0, 0, 0, 0);
        rx_full = 1; byte_valid = 1; #1;
        chk("R9 drain left counter, R10 overflow", {rx_keep, rx_overflow}, 2'b01);
        tick();
        rx_full = 0;

        // random traffic checked cycle by cycle
        for (int i = 0; i < 2000; i++) begin
            cs_assert    = ($urandom % 12) == 0;
            byte_valid   = ($urandom % 4) != 0;
            ext_addr     = $urandom % 2;
            dec_known    = ($urandom % 5) != 0;
            dec_dummies  = 4'($urandom % 4);
            dec_lanes    = 2'($urandom % 4);
            discard_init = (($urandom % 4) == 0) ? 7'($urandom) : 7'd0;
            rx_drain     = ($urandom % 10) == 0;
            rx_full      = ($urandom % 8) == 0;
            stripe_en    = $urandom % 2;
            tx_pair_in   = 16'($urandom);
            rx_pair_in   = 16'($urandom);
            tick();
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule